// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block arbitrates among 32 external interrupt lines and two fixed-rank system exceptions (a non-maskable request and a fault request). Each external line has an enable bit and a pending bit. Software changes these through separate write-one-to-set and write-one-to-clear words. Each line also has a 2-bit priority level, and four lines share one 32-bit word. Hardware requests set pending bits. A line built as pulse-sensitive pends on a rising edge. A line built as level-sensitive pends for as long as it is high and not active. Which lines are pulse-sensitive is fixed by a parameter mask.

On every cycle the controller picks the winning exception among those that are pending and enabled. It drives that exception's number and raises a request strobe when the winner strictly outranks the highest-ranked exception the core is running. The core reports that it has taken an exception by giving its number with an acknowledge strobe. This clears the pending bit and marks the exception active. A completion strobe retires the innermost active exception, which is always the highest-ranked active one. Vector fetch, the core and the bus are outside the block.

Top module: `pvic_top`

## Requirements
- R1: External line k (0..31) is reported as exception number 16+k. The non-maskable request is exception 2 and the fault request is exception 3.
- R2: Lines whose bit is set in parameter PULSE_LINES (default: lines 16..31) pend only on a 0-to-1 transition, so holding one high after its pending bit is cleared does not re-pend it. The other lines pend on every cycle in which they are high and not active, so a software clear of a high level line has no lasting effect.
- R3: A write to word 0 sets the enable bit of every line whose data bit is 1. A write to word 1 clears the enable bit of every line whose data bit is 1. Data bits of 0 leave the enable bits unchanged. Words 0 and 1 both read back the enable vector, with bit k for line k.
- R4: A write to word 2 pends each line whose data bit is 1. A write to word 3 un-pends each line whose data bit is 1. Words 2 and 3 both read back the line pending vector.
- R5: Words 8..15 hold the priorities. Line k sits in word 8+k/4, byte lane k%4, bits [8*(k%4)+7 : 8*(k%4)+6]. All other bits of these words read as zero.
- R6: A lower priority level wins. Both system exceptions outrank every line, and the non-maskable request outranks the fault request.
- R7: Among pending, enabled exceptions with equal rank, the lowest exception number wins.
- R8: req_o is high only when the winner's rank is strictly better than the highest-ranked active exception's rank, or when nothing is active. An equal rank never raises req_o.
- R9: ack_i with a valid number clears that exception's pending bit and makes it active. act_num_o shows the highest-ranked active exception, or 0 when none is active.
- R10: done_i retires the highest-ranked active exception. A level line that is still high when it is retired pends again at that same clock edge.
- R11: A pending line whose enable bit is clear stays pending but is never selected.
- R12: Register writes, request inputs, acknowledges and completions are all reflected on req_o, req_num_o, act_num_o and the read data after exactly one rising clock edge. Reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_i | input | 32 | External interrupt request lines |
| sys_irq_i | input | 2 | Bit 0 non-maskable request, bit 1 fault request (both rising-edge) |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register word index for writes |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 4 | Register word index for reads |
| rd_data_o | output | 32 | Combinational read data |
| ack_i | input | 1 | Core has taken exception ack_num_i |
| ack_num_i | input | 6 | Number of the exception being taken |
| done_i | input | 1 | Core has finished the innermost active exception |
| req_o | output | 1 | Winner outranks the active exception and should be taken |
| req_num_o | output | 6 | Exception number of the current winner |
| act_num_o | output | 6 | Highest-ranked active exception, 0 if none |

## Verification
Every piece of state sits in one register stage, and the arbitration and reads are combinational from it. Any stimulus applied before a rising edge therefore shows up on the outputs just after that edge, one cycle later. The bench drives its inputs on falling edges and holds each one through exactly one rising edge. It then checks req_o, req_num_o, act_num_o and the read data on the next falling edge, and for reads it waits one time unit after setting the read index. Where a requirement concerns something that should not happen (a pulse line held high, an equal-rank request), the bench waits one more full cycle before checking, so that a late effect would also be seen.

// File: rtl/pvic_pkg.sv
package pvic_pkg;

    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 4;
    localparam int EXC_W     = 6;
    localparam int LANE_W    = 8;
    localparam int LANES     = DATA_W / LANE_W;
    localparam int NUM_SYS   = 2;
    localparam int SYS_BASE  = 2;
    localparam int LINE_BASE = 16;

    localparam logic [ADDR_W-1:0] A_EN_SET   = 4'd0;
    localparam logic [ADDR_W-1:0] A_EN_CLR   = 4'd1;
    localparam logic [ADDR_W-1:0] A_PEND_SET = 4'd2;
    localparam logic [ADDR_W-1:0] A_PEND_CLR = 4'd3;

endpackage

// File: rtl/pvic_sense.sv
// Request conditioning: per bit, either a rising-edge detector or a pass-through level.
module pvic_sense #(
    parameter int           N          = 34,
    parameter logic [N-1:0] PULSE_MASK = '0
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] lvl_i,
    output logic [N-1:0] hit_o
);

    logic [N-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = lvl_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prev_q <= '0;
        else         prev_q <= prev_d;
    end

    for (genvar g = 0; g < N; g++) begin : g_bit
        if (PULSE_MASK[g]) begin : g_edge
            assign hit_o[g] = lvl_i[g] & ~prev_q[g];
        end else begin : g_level
            assign hit_o[g] = lvl_i[g] | (prev_q[g] & 1'b0);
        end
    end

endmodule

// File: rtl/pvic_pick.sv
// Linear rank scan: best (lowest) rank wins, strict compare keeps the lowest index on ties.
module pvic_pick #(
    parameter int N      = 34,
    parameter int IDX_W  = 6,
    parameter int RANK_W = 3
) (
    input  logic [N-1:0]        cand_i,
    input  logic [N*RANK_W-1:0] rank_i,
    output logic                found_o,
    output logic [IDX_W-1:0]    idx_o,
    output logic [RANK_W-1:0]   rank_o
);

    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        rank_o  = '1;
        for (int i = 0; i < N; i++) begin
            if (cand_i[i] && (!found_o || (rank_i[i*RANK_W +: RANK_W] < rank_o))) begin
                found_o = 1'b1;
                idx_o   = IDX_W'(i);
                rank_o  = rank_i[i*RANK_W +: RANK_W];
            end
        end
    end

endmodule

// File: rtl/pvic_top.sv
module pvic_top
    import pvic_pkg::*;
#(
    parameter int                  NUM_LINES   = 32,
    parameter int                  PRIO_W      = 2,
    parameter logic [NUM_LINES-1:0] PULSE_LINES = 32'hFFFF_0000
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [NUM_LINES-1:0] irq_i,
    input  logic [1:0]           sys_irq_i,
    input  logic                 wr_en_i,
    input  logic [ADDR_W-1:0]    wr_addr_i,
    input  logic [DATA_W-1:0]    wr_data_i,
    input  logic [ADDR_W-1:0]    rd_addr_i,
    output logic [DATA_W-1:0]    rd_data_o,
    input  logic                 ack_i,
    input  logic [EXC_W-1:0]     ack_num_i,
    input  logic                 done_i,
    output logic                 req_o,
    output logic [EXC_W-1:0]     req_num_o,
    output logic [EXC_W-1:0]     act_num_o
);

    localparam int NUM_EXC = NUM_SYS + NUM_LINES;
    localparam int IDX_W   = $clog2(NUM_EXC);
    localparam int RANK_W  = $clog2(NUM_SYS + (1 << PRIO_W) + 1);
    localparam int PRIO_LO = LANE_W - PRIO_W;

    localparam logic [NUM_EXC-1:0] PULSE_ALL = {PULSE_LINES, {NUM_SYS{1'b1}}};
    localparam logic [NUM_EXC-1:0] LEVEL_ALL = ~PULSE_ALL;

    typedef struct packed {
        logic [NUM_LINES-1:0]        en;
        logic [NUM_EXC-1:0]          pend;
        logic [NUM_EXC-1:0]          act;
        logic [NUM_LINES*PRIO_W-1:0] prio;
    } state_t;

    state_t s_d, s_q;

    function automatic logic [EXC_W-1:0] idx2exc(logic [IDX_W-1:0] i);
        if (int'(i) < NUM_SYS) return EXC_W'(int'(i) + SYS_BASE);
        return EXC_W'(int'(i) - NUM_SYS + LINE_BASE);
    endfunction

    // request conditioning
    logic [NUM_EXC-1:0] hit;

    pvic_sense #(
        .N          (NUM_EXC),
        .PULSE_MASK (PULSE_ALL)
    ) u_sense (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .lvl_i  ({irq_i, sys_irq_i}),
        .hit_o  (hit)
    );

    // ranks: system exceptions take 0..NUM_SYS-1, lines follow in level order
    logic [NUM_EXC*RANK_W-1:0] rank;

    always_comb begin
        rank = '0;
        for (int i = 0; i < NUM_EXC; i++) begin
            if (i < NUM_SYS) begin
                rank[i*RANK_W +: RANK_W] = RANK_W'(i);
            end else begin
                rank[i*RANK_W +: RANK_W] = RANK_W'(NUM_SYS)
                    + RANK_W'(s_q.prio[(i-NUM_SYS)*PRIO_W +: PRIO_W]);
            end
        end
    end

    // arbitration over pending+enabled, and over active
    logic [NUM_EXC-1:0] elig;
    logic               best_found, top_found;
    logic [IDX_W-1:0]   best_idx, top_idx;
    logic [RANK_W-1:0]  best_rank, top_rank, act_rank;

    always_comb begin
        elig = s_q.pend & {s_q.en, {NUM_SYS{1'b1}}};
    end

    pvic_pick #(.N(NUM_EXC), .IDX_W(IDX_W), .RANK_W(RANK_W)) u_best (
        .cand_i  (elig),
        .rank_i  (rank),
        .found_o (best_found),
        .idx_o   (best_idx),
        .rank_o  (best_rank)
    );

    pvic_pick #(.N(NUM_EXC), .IDX_W(IDX_W), .RANK_W(RANK_W)) u_top (
        .cand_i  (s_q.act),
        .rank_i  (rank),
        .found_o (top_found),
        .idx_o   (top_idx),
        .rank_o  (top_rank)
    );

    always_comb begin
        act_rank  = top_found ? top_rank : '1;
        req_o     = best_found && (best_rank < act_rank);
        req_num_o = best_found ? idx2exc(best_idx) : '0;
        act_num_o = top_found ? idx2exc(top_idx) : '0;
    end

    // acknowledge number decode
    logic             ack_ok;
    logic [IDX_W-1:0] ack_idx;

    always_comb begin
        ack_ok  = 1'b0;
        ack_idx = '0;
        if (int'(ack_num_i) >= SYS_BASE && int'(ack_num_i) < SYS_BASE + NUM_SYS) begin
            ack_ok  = 1'b1;
            ack_idx = IDX_W'(int'(ack_num_i) - SYS_BASE);
        end else if (int'(ack_num_i) >= LINE_BASE && int'(ack_num_i) < LINE_BASE + NUM_LINES) begin
            ack_ok  = 1'b1;
            ack_idx = IDX_W'(int'(ack_num_i) - LINE_BASE + NUM_SYS);
        end
    end

    // next state
    logic [NUM_EXC-1:0] ack_vec, done_vec, sw_set, sw_clr, hw_set;

    always_comb begin
        s_d      = s_q;
        ack_vec  = '0;
        done_vec = '0;
        sw_set   = '0;
        sw_clr   = '0;

        if (ack_i && ack_ok)     ack_vec[ack_idx]  = 1'b1;
        if (done_i && top_found) done_vec[top_idx] = 1'b1;
        s_d.act = (s_q.act & ~done_vec) | ack_vec;

        if (wr_en_i) begin
            case (wr_addr_i)
                A_EN_SET:   s_d.en = s_q.en |  wr_data_i[NUM_LINES-1:0];
                A_EN_CLR:   s_d.en = s_q.en & ~wr_data_i[NUM_LINES-1:0];
                A_PEND_SET: sw_set = {wr_data_i[NUM_LINES-1:0], {NUM_SYS{1'b0}}};
                A_PEND_CLR: sw_clr = {wr_data_i[NUM_LINES-1:0], {NUM_SYS{1'b0}}};
                default: begin
                    if (wr_addr_i[ADDR_W-1]) begin
                        for (int b = 0; b < LANES; b++) begin
                            if (int'(wr_addr_i[ADDR_W-2:0]) * LANES + b < NUM_LINES) begin
                                s_d.prio[(int'(wr_addr_i[ADDR_W-2:0]) * LANES + b) * PRIO_W +: PRIO_W]
                                    = wr_data_i[b*LANE_W + PRIO_LO +: PRIO_W];
                            end
                        end
                    end
                end
            endcase
        end

        // a level line re-pends only while not active in the next state
        hw_set  = hit & ~(LEVEL_ALL & s_d.act);
        s_d.pend = (s_q.pend & ~ack_vec & ~sw_clr) | hw_set | sw_set;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    // read port
    always_comb begin
        rd_data_o = '0;
        case (rd_addr_i)
            A_EN_SET, A_EN_CLR:     rd_data_o = DATA_W'(s_q.en);
            A_PEND_SET, A_PEND_CLR: rd_data_o = DATA_W'(s_q.pend[NUM_EXC-1:NUM_SYS]);
            default: begin
                if (rd_addr_i[ADDR_W-1]) begin
                    for (int b = 0; b < LANES; b++) begin
                        if (int'(rd_addr_i[ADDR_W-2:0]) * LANES + b < NUM_LINES) begin
                            rd_data_o[b*LANE_W + PRIO_LO +: PRIO_W]
                                = s_q.prio[(int'(rd_addr_i[ADDR_W-2:0]) * LANES + b) * PRIO_W +: PRIO_W];
                        end
                    end
                end
            end
        endcase
    end

    // state views for the bound checker
    logic [NUM_LINES-1:0] en_view;
    logic [NUM_EXC-1:0]   act_view;

    always_comb begin
        en_view  = s_q.en;
        act_view = s_q.act;
    end

endmodule

// File: rtl/pvic_checker.sv
module pvic_checker
    import pvic_pkg::*;
#(
    parameter int NUM_LINES = 32,
    parameter int PRIO_W    = 2
) (
    input logic                        clk_i,
    input logic                        rst_ni,
    input logic                        wr_en_i,
    input logic [ADDR_W-1:0]           wr_addr_i,
    input logic [DATA_W-1:0]           wr_data_i,
    input logic [ADDR_W-1:0]           rd_addr_i,
    input logic [DATA_W-1:0]           rd_data_o,
    input logic                        ack_i,
    input logic [EXC_W-1:0]            ack_num_i,
    input logic                        done_i,
    input logic                        req_o,
    input logic [EXC_W-1:0]            req_num_o,
    input logic [EXC_W-1:0]            act_num_o,
    input logic [NUM_LINES-1:0]        en_view,
    input logic [NUM_SYS+NUM_LINES-1:0] act_view
);

    localparam int NUM_EXC = NUM_SYS + NUM_LINES;
    localparam int IDX_W   = $clog2(NUM_EXC);
    localparam logic [LANE_W-1:0] LANE_USED = {{PRIO_W{1'b1}}, {(LANE_W-PRIO_W){1'b0}}};
    localparam logic [DATA_W-1:0] RSV_BITS  = ~{LANES{LANE_USED}};

    logic             chk_ack_ok;
    logic [IDX_W-1:0] chk_ack_idx;

    always_comb begin
        chk_ack_ok  = 1'b0;
        chk_ack_idx = '0;
        if (ack_num_i == EXC_W'(SYS_BASE) || ack_num_i == EXC_W'(SYS_BASE + 1)) begin
            chk_ack_ok  = 1'b1;
            chk_ack_idx = IDX_W'(ack_num_i) - IDX_W'(SYS_BASE);
        end else if (ack_num_i >= EXC_W'(LINE_BASE)
                     && int'(ack_num_i) <= LINE_BASE + NUM_LINES - 1) begin
            chk_ack_ok  = 1'b1;
            chk_ack_idx = IDX_W'(int'(ack_num_i) - LINE_BASE + NUM_SYS);
        end
    end

    assert_enable_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_addr_i == A_EN_SET) |=>
            ((en_view & $past(wr_data_i[NUM_LINES-1:0])) == $past(wr_data_i[NUM_LINES-1:0])));

    assert_enable_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_addr_i == A_EN_CLR) |=>
            ((en_view & $past(wr_data_i[NUM_LINES-1:0])) == '0));

    assert_enable_zero_bits_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && (wr_addr_i == A_EN_SET || wr_addr_i == A_EN_CLR)) |=>
            ((en_view & ~$past(wr_data_i[NUM_LINES-1:0]))
             == ($past(en_view) & ~$past(wr_data_i[NUM_LINES-1:0]))));

    assert_prio_reserved_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_addr_i[ADDR_W-1] |-> ((rd_data_o & RSV_BITS) == '0));

    assert_no_equal_preempt_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_o |-> (req_num_o != act_num_o));

    assert_ack_activates_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack_i && chk_ack_ok && !done_i) |=> act_view[$past(chk_ack_idx)]);

    assert_done_retires_one_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_i && !ack_i && act_view != '0) |=>
            ($countones(act_view) == $countones($past(act_view)) - 1));

endmodule

bind pvic_top pvic_checker #(
    .NUM_LINES (NUM_LINES),
    .PRIO_W    (PRIO_W)
) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o),
    .ack_i     (ack_i),
    .ack_num_i (ack_num_i),
    .done_i    (done_i),
    .req_o     (req_o),
    .req_num_o (req_num_o),
    .act_num_o (act_num_o),
    .en_view   (en_view),
    .act_view  (act_view)
);

// File: tb/tb_pvic_top.sv
module tb_pvic_top;
    import pvic_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq = '0;
    logic [1:0]  sys_irq = '0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        ack = 1'b0;
    logic [5:0]  ack_num = '0;
    logic        done = 1'b0;
    logic        req;
    logic [5:0]  req_num;
    logic [5:0]  act_num;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [31:0] m_en, m_pend;
    logic [1:0]  m_prio [32];

    always #4 clk = ~clk;

    pvic_top dut (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .irq_i     (irq),
        .sys_irq_i (sys_irq),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data),
        .ack_i     (ack),
        .ack_num_i (ack_num),
        .done_i    (done),
        .req_o     (req),
        .req_num_o (req_num),
        .act_num_o (act_num)
    );

    task automatic chk(string tag, logic [31:0] actual, logic [31:0] expected);
        checks++;
        if (actual !== expected) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, actual, expected);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rdchk(string tag, logic [3:0] a, logic [31:0] expected);
        rd_addr = a;
        #1;
        chk(tag, rd_data, expected);
    endtask

    task automatic take(logic [5:0] n);
        @(negedge clk);
        ack = 1'b1; ack_num = n;
        @(negedge clk);
        ack = 1'b0;
    endtask

    task automatic retire();
        @(negedge clk);
        done = 1'b1;
        @(negedge clk);
        done = 1'b0;
    endtask

    // model of selection with nothing active: {found, number}
    function automatic logic [6:0] model_pick();
        logic       found = 1'b0;
        logic [1:0] best  = '0;
        logic [5:0] num   = '0;
        for (int k = 0; k < 32; k++) begin
            if (m_en[k] && m_pend[k] && (!found || m_prio[k] < best)) begin
                found = 1'b1;
                best  = m_prio[k];
                num   = 6'(16 + k);
            end
        end
        return {found, num};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [6:0] exp_sel;
        void'($urandom(32'd20240611));
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // reset state
        chk("R12 reset req", 32'(req), 32'h0);
        chk("R9 reset act_num", 32'(act_num), 32'h0);
        rdchk("R3 reset enable", 4'd0, 32'h0);
        rdchk("R4 reset pending", 4'd2, 32'h0);
        rdchk("R5 reset prio", 4'd8, 32'h0);

        // constrained random selection, nothing active, no hardware requests
        for (int it = 0; it < 100; it++) begin
            m_en   = $urandom;
            m_pend = $urandom & $urandom;
            for (int w = 0; w < 8; w++) begin
                logic [31:0] d = $urandom;
                wr(4'(8 + w), d);
                for (int b = 0; b < 4; b++) m_prio[w*4+b] = d[b*8+6 +: 2];
            end
            wr(A_EN_CLR, 32'hFFFF_FFFF);
            wr(A_EN_SET, m_en);
            wr(A_PEND_CLR, 32'hFFFF_FFFF);
            wr(A_PEND_SET, m_pend);
            exp_sel = model_pick();
            chk("R6 R7 R11 random req", 32'(req), 32'(exp_sel[6]));
            if (exp_sel[6]) chk("R1 R6 R7 random num", 32'(req_num), 32'(exp_sel[5:0]));
            if (it % 10 == 0) begin
                rdchk("R4 random pending", 4'd3, m_pend);
                rdchk("R3 random enable", 4'd1, m_en);
                rdchk("R5 random prio word", 4'd9,
                      {m_prio[7], 6'd0, m_prio[6], 6'd0, m_prio[5], 6'd0, m_prio[4], 6'd0});
            end
        end

        // directed: clean slate
        wr(A_EN_CLR, 32'hFFFF_FFFF);
        wr(A_PEND_CLR, 32'hFFFF_FFFF);
        for (int w = 0; w < 8; w++) wr(4'(8 + w), 32'h0);

        // R3 zero bits no effect
        wr(A_EN_SET, 32'h0000_00A0);
        wr(A_EN_SET, 32'h0);
        rdchk("R3 set zero no effect", 4'd0, 32'h0000_00A0);
        wr(A_EN_CLR, 32'h0000_0080);
        rdchk("R3 clear one bit", 4'd0, 32'h0000_0020);
        wr(A_EN_CLR, 32'hFFFF_FFFF);

        // R5 reserved bits
        wr(4'd10, 32'hFFFF_FFFF);
        rdchk("R5 reserved zero", 4'd10, 32'hC0C0_C0C0);
        wr(4'd10, 32'h0);

        // R11 disabled stays pending, R1 number
        wr(A_PEND_SET, 32'h0000_0020);
        chk("R11 disabled no req", 32'(req), 32'h0);
        rdchk("R4 set pending", 4'd2, 32'h0000_0020);
        wr(A_EN_SET, 32'h0000_0020);
        chk("R1 line 5 req", 32'(req), 32'h1);
        chk("R1 line 5 num", 32'(req_num), 32'd21);

        // R7 tie
        wr(A_PEND_SET, 32'h0000_0008);
        wr(A_EN_SET, 32'h0000_0008);
        chk("R7 tie lowest number", 32'(req_num), 32'd19);

        // R6 level order, then system exception
        wr(4'd8, 32'h4000_0000);
        chk("R6 lower level wins", 32'(req_num), 32'd21);
        @(negedge clk); sys_irq[0] = 1'b1;
        step();
        chk("R6 system outranks lines", 32'(req_num), 32'd2);

        // R9 activation
        take(6'd2);
        chk("R9 act num", 32'(act_num), 32'd2);
        chk("R8 no preempt of higher", 32'(req), 32'h0);
        retire();
        chk("R10 retired", 32'(act_num), 32'd0);
        chk("R2 held pulse no re-pend", 32'(req_num), 32'd21);

        // R8 equal rank blocked, strictly higher allowed
        take(6'd21);
        wr(A_PEND_SET, 32'h0000_0080);
        wr(A_EN_SET, 32'h0000_0080);
        step();
        chk("R8 equal rank no req", 32'(req), 32'h0);
        @(negedge clk); sys_irq[1] = 1'b1;
        step();
        chk("R8 higher rank req", 32'(req), 32'h1);
        chk("R8 higher rank num", 32'(req_num), 32'd3);
        take(6'd3);
        chk("R9 nested act", 32'(act_num), 32'd3);
        retire();
        chk("R10 inner retired first", 32'(act_num), 32'd21);
        retire();
        chk("R10 all retired", 32'(act_num), 32'd0);
        chk("R6 R7 after retire", 32'(req_num), 32'd23);
        wr(A_PEND_CLR, 32'hFFFF_FFFF);
        chk("R4 clear pending", 32'(req), 32'h0);
        wr(A_EN_CLR, 32'hFFFF_FFFF);

        // R2 pulse line 20
        wr(A_EN_SET, 32'h0010_0000);
        @(negedge clk); irq[20] = 1'b1;
        step();
        rdchk("R2 pulse pends", 4'd2, 32'h0010_0000);
        wr(A_PEND_CLR, 32'h0010_0000);
        step();
        rdchk("R2 pulse held no re-pend", 4'd2, 32'h0);
        @(negedge clk); irq[20] = 1'b0;
        wr(A_EN_CLR, 32'hFFFF_FFFF);

        // R2 level line 2, R10 re-pend after completion
        wr(A_EN_SET, 32'h0000_0004);
        @(negedge clk); irq[2] = 1'b1;
        step();
        rdchk("R2 level pends", 4'd2, 32'h0000_0004);
        wr(A_PEND_CLR, 32'h0000_0004);
        rdchk("R2 level clear no effect", 4'd2, 32'h0000_0004);
        take(6'd18);
        step();
        rdchk("R9 ack clears pending", 4'd2, 32'h0);
        retire();
        rdchk("R10 level re-pends", 4'd2, 32'h0000_0004);
        chk("R10 level re-request", 32'(req_num), 32'd18);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule